// File: doc/BRIEF.md
# Local Interrupt Take Selector

This block decides, for one hart, whether a local interrupt should be taken now and which one. It combines a pending vector and an enable vector with the current privilege level, the machine and supervisor global interrupt-enable bits, and a per-interrupt delegation mask. It reports a valid flag and the cause number of the winning interrupt.

A line is a candidate when it is both pending and enabled. Each candidate is then gated by the global enable of the level that handles it. A clear delegation bit means the machine level handles the line; a set bit means the supervisor level handles it. A level's global enable is always open while the hart runs below that level. At that level it follows the matching IE bit. Above that level it is shut. Among the lines that survive, the one with the lowest index wins.

The default build is purely combinational. A parameter can add an optional output register. The block is meant to feed the trap-entry logic of a core, which decides when to sample its result.

Top module: `irq_take_select`

## Requirements
- R1: A line is a candidate only when its pending bit and its enable bit are both 1; a line whose enable bit is 0 is never reported.
- R2: Lines with delegation bit 0 are open whenever privilege is U (0) or S (1). At privilege M (3) they are open only when the machine IE input is 1.
- R3: Lines with delegation bit 1 are always open at privilege U. At privilege S they are open only when the supervisor IE input is 1. At privilege M they are never open.
- R4: A line with delegation bit 0 is gated only by the machine-level enable of R2. The supervisor IE input has no effect on it.
- R5: A line with delegation bit 1 is gated only by the supervisor-level enable of R3. The machine IE input has no effect on it.
- R6: When one or more lines survive gating, irq_valid is 1 and irq_cause is the index of the lowest surviving line (bit 0 wins over all others).
- R7: When no line survives gating, irq_valid is 0 and irq_cause is 0.
- R8: The privilege encoding 2 behaves exactly like U (0).
- R9: With the default OUT_REG = 0, the outputs follow an input change within the same clock cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Active-low reset |
| irq_pending | input | 16 | Pending bit per interrupt line |
| irq_enable | input | 16 | Enable bit per interrupt line |
| irq_deleg | input | 16 | 1 = line handled at supervisor level, 0 = machine level |
| cur_priv | input | 2 | Current privilege: 0 U, 1 S, 2 treated as U, 3 M |
| mach_ie | input | 1 | Machine global interrupt enable |
| supv_ie | input | 1 | Supervisor global interrupt enable |
| irq_valid | output | 1 | An interrupt should be taken |
| irq_cause | output | 4 | Index of the selected line, 0 when none |

## Verification
Single-line vectors placed at bit 0, a middle bit and bit 15 show whether the index encoding is right at both ends. Dense vectors such as all-ones, and pairs of lines, show whether the lowest line wins. Vectors that mix delegated and undelegated lines while the two IE bits are set to opposite values show whether each line is gated by its own level, not by the other level. Sweeps of all four privilege codes, together with random traffic compared against a behavioural model on every clock, separate the open, IE-controlled and shut cases of each level.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUPV = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_MACH = 2'd3
  } priv_e;

  // Fold the unused privilege code onto the user level.
  function automatic priv_e priv_rank(input logic [1:0] raw);
    priv_e r;
    if (raw == 2'd2) r = PRIV_USER;
    else             r = priv_e'(raw);
    return r;
  endfunction

  // A handling level is open below it, IE-controlled at it, shut above it.
  function automatic logic level_open(input priv_e cur, input priv_e lvl,
                                      input logic ie);
    logic o;
    if (cur < lvl)       o = 1'b1;
    else if (cur == lvl) o = ie;
    else                 o = 1'b0;
    return o;
  endfunction

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_sel_pkg::*;
(
  input  logic [1:0] priv_raw,
  input  logic       m_ie,
  input  logic       s_ie,
  output logic       m_open,
  output logic       s_open
);

  priv_e rank;

  always_comb begin
    rank   = priv_rank(priv_raw);
    m_open = level_open(rank, PRIV_MACH, m_ie);
    s_open = level_open(rank, PRIV_SUPV, s_ie);
  end

endmodule

// File: rtl/irq_candidate_mask.sv
module irq_candidate_mask #(
  parameter int N = 16
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] en,
  input  logic [N-1:0] deleg,
  input  logic         m_open,
  input  logic         s_open,
  output logic [N-1:0] cand,
  output logic [N-1:0] gated
);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic lvl_open;
    assign lvl_open = deleg[i] ? s_open : m_open;
    assign cand[i]  = pend[i] & en[i];
    assign gated[i] = cand[i] & lvl_open;
  end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N  = 16,
  parameter int CW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          hit,
  output logic [CW-1:0] idx
);

  function automatic logic [CW-1:0] first_one(input logic [N-1:0] v);
    logic [CW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = CW'(i);
    end
    return r;
  endfunction

  always_comb begin
    hit = |vec;
    idx = first_one(vec);
  end

endmodule

// File: rtl/irq_take_select.sv
module irq_take_select #(
  parameter int NUM_IRQ = 16,
  parameter bit OUT_REG = 1'b0,
  localparam int CAUSE_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_enable,
  input  logic [NUM_IRQ-1:0] irq_deleg,
  input  logic [1:0]         cur_priv,
  input  logic               mach_ie,
  input  logic               supv_ie,
  output logic               irq_valid,
  output logic [CAUSE_W-1:0] irq_cause
);

  logic               m_open, s_open;
  logic [NUM_IRQ-1:0] cand, gated;
  logic               sel_valid;
  logic [CAUSE_W-1:0] sel_cause;

  irq_level_gate u_level (
    .priv_raw (cur_priv),
    .m_ie     (mach_ie),
    .s_ie     (supv_ie),
    .m_open   (m_open),
    .s_open   (s_open)
  );

  irq_candidate_mask #(.N(NUM_IRQ)) u_mask (
    .pend   (irq_pending),
    .en     (irq_enable),
    .deleg  (irq_deleg),
    .m_open (m_open),
    .s_open (s_open),
    .cand   (cand),
    .gated  (gated)
  );

  irq_lowest_pick #(.N(NUM_IRQ), .CW(CAUSE_W)) u_pick (
    .vec (gated),
    .hit (sel_valid),
    .idx (sel_cause)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_valid <= 1'b0;
        irq_cause <= '0;
      end else begin
        irq_valid <= sel_valid;
        irq_cause <= sel_cause;
      end
    end
  end else begin : g_comb
    assign irq_valid = sel_valid;
    assign irq_cause = sel_cause;
  end

  // R1: the winner is pending and enabled at the ports
  a_r1_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (irq_pending[sel_cause] && irq_enable[sel_cause]));

  // R2: machine level shut only at M with IE clear
  a_r2_mach_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_open) |-> (cur_priv == 2'd3 && !mach_ie));

  // R3: supervisor level never open at M
  a_r3_supv_shut_at_m: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv == 2'd3) |-> !s_open);

  // R4: an undelegated winner needs the machine level open
  a_r4_undeleg_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !irq_deleg[sel_cause]) |-> m_open);

  // R5: a delegated winner needs the supervisor level open
  a_r5_deleg_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && irq_deleg[sel_cause]) |-> s_open);

  // R6: nothing eligible sits below the winner
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ((gated & (({{(NUM_IRQ-1){1'b0}}, 1'b1} << sel_cause)
                             - {{(NUM_IRQ-1){1'b0}}, 1'b1})) == '0));

  // R7: no winner means nothing eligible and a zero cause
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_valid) |-> (gated == '0 && sel_cause == '0));

  // R8: code 2 leaves both levels open
  a_r8_rsvd_as_user: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv == 2'd2) |-> (m_open && s_open));

endmodule

// File: tb/tb_irq_take_select.sv
module tb_irq_take_select;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pend = '0, en = '0, dlg = '0;
  logic [1:0]  priv = 2'd0;
  logic        mie = 1'b0, sie = 1'b0;
  logic        v;
  logic [3:0]  c;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  irq_take_select dut (
    .clk(clk), .rst_n(rst_n), .irq_pending(pend), .irq_enable(en),
    .irq_deleg(dlg), .cur_priv(priv), .mach_ie(mie), .supv_ie(sie),
    .irq_valid(v), .irq_cause(c)
  );

  // behavioural reference, written from the requirements
  task automatic model(output logic ev, output logic [3:0] ec);
    int lvl, m_ok, s_ok;
    lvl  = (priv == 2'd3) ? 3 : (priv == 2'd1) ? 1 : 0;
    m_ok = (lvl < 3) || mie;
    s_ok = (lvl == 0) || (lvl == 1 && sie);
    ev = 1'b0; ec = 4'd0;
    for (int i = 0; i < 16; i++) begin
      if (!ev && pend[i] && en[i] && (dlg[i] ? s_ok : m_ok) != 0) begin
        ev = 1'b1; ec = 4'(i);
      end
    end
  endtask

  task automatic check(input string req, input logic ev, input logic [3:0] ec);
    n_run++;
    if (v !== ev || c !== ec) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b cause=%0d, expected valid=%0b cause=%0d",
               req, v, c, ev, ec);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] p, input logic [15:0] e,
                       input logic [15:0] d, input logic [1:0] pr,
                       input logic m, input logic s,
                       input logic ev, input logic [3:0] ec);
    logic mv; logic [3:0] mc;
    @(negedge clk);
    pend = p; en = e; dlg = d; priv = pr; mie = m; sie = s;
    #2;
    check(req, ev, ec);
    model(mv, mc);
    check({req, " model"}, mv, mc);
  endtask

  // compare against the model on every clock
  always @(posedge clk) begin
    logic mv; logic [3:0] mc;
    if (rst_n && !done) begin
      #1;
      model(mv, mc);
      check("R6 per-clock", mv, mc);
    end
  end

  initial begin
    #2;
    check("R7 reset idle", 1'b0, 4'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    apply("R1 not enabled",        16'h0010, 16'h0000, 16'h0000, 2'd3, 1, 1, 0, 4'd0);
    apply("R1 enabled",            16'h0010, 16'h0010, 16'h0000, 2'd3, 1, 1, 1, 4'd4);
    apply("R2 M with mie=0",       16'h0080, 16'hFFFF, 16'h0000, 2'd3, 0, 1, 0, 4'd0);
    apply("R2 S ignores mie",      16'h0080, 16'hFFFF, 16'h0000, 2'd1, 0, 0, 1, 4'd7);
    apply("R2 U ignores mie",      16'h0080, 16'hFFFF, 16'h0000, 2'd0, 0, 0, 1, 4'd7);
    apply("R3 S with sie=0",       16'h0020, 16'hFFFF, 16'h0020, 2'd1, 1, 0, 0, 4'd0);
    apply("R3 S with sie=1",       16'h0020, 16'hFFFF, 16'h0020, 2'd1, 0, 1, 1, 4'd5);
    apply("R3 M shuts delegated",  16'h0020, 16'hFFFF, 16'h0020, 2'd3, 1, 1, 0, 4'd0);
    apply("R3 U opens delegated",  16'h0020, 16'hFFFF, 16'h0020, 2'd0, 0, 0, 1, 4'd5);
    apply("R4 sie no effect",      16'h0022, 16'hFFFF, 16'h0002, 2'd1, 0, 0, 1, 4'd5);
    apply("R4 undeleg at M",       16'h0022, 16'hFFFF, 16'h0002, 2'd3, 1, 0, 1, 4'd5);
    apply("R5 mie no effect",      16'h0022, 16'hFFFF, 16'h0020, 2'd1, 0, 1, 1, 4'd1);
    apply("R5 delegated lower",    16'h0022, 16'hFFFF, 16'h0002, 2'd1, 1, 1, 1, 4'd1);
    apply("R6 all ones",           16'hFFFF, 16'hFFFF, 16'h0000, 2'd3, 1, 0, 1, 4'd0);
    apply("R6 top bit",            16'h8000, 16'hFFFF, 16'h0000, 2'd3, 1, 0, 1, 4'd15);
    apply("R6 pair",               16'hA000, 16'hFFFF, 16'h0000, 2'd3, 1, 0, 1, 4'd13);
    apply("R6 masked low",         16'h0105, 16'hFF04, 16'h0000, 2'd3, 1, 0, 1, 4'd2);
    apply("R7 nothing pending",    16'h0000, 16'hFFFF, 16'hFFFF, 2'd0, 1, 1, 0, 4'd0);
    apply("R8 code 2 like U",      16'h0009, 16'hFFFF, 16'h0008, 2'd2, 0, 0, 1, 4'd0);
    apply("R8 code 2 delegated",   16'h0008, 16'hFFFF, 16'h0008, 2'd2, 0, 0, 1, 4'd3);

    // R9: change inputs just after an edge and observe before the next one
    @(posedge clk); #1;
    pend = 16'h0400; en = 16'hFFFF; dlg = '0; priv = 2'd3; mie = 1'b1;
    #1;
    check("R9 same-cycle response", 1'b1, 4'd10);

    for (int k = 0; k < 400; k++) begin
      logic mv; logic [3:0] mc;
      @(negedge clk);
      pend = 16'($urandom) & 16'($urandom);
      en   = 16'($urandom);
      dlg  = 16'($urandom);
      priv = 2'($urandom);
      mie  = 1'($urandom);
      sie  = 1'($urandom);
      #2;
      model(mv, mc);
      check("R6 random", mv, mc);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule